// File: doc/BRIEF.md
# Serial Display Write Controller

This block is a transmit-only serial master for a small display controller. Each request arrives through a valid/ready handshake and is one of three kinds. A single 8-bit command is the first kind. An extended command is the second kind: an 8-bit command with an 8-bit parameter, sent as one 16-bit frame. A burst of 16-bit data words is the third kind. The burst words are pulled from a separate word stream, and the request gives the word count. The controller drives four outputs: an active-low chip select, a register-select line, a serial clock that idles high, and a serial data line.

The display samples data on the rising serial clock edge. For this reason, the data line only moves together with a falling clock edge. During the high phase it is held still. Chip select stays low across a whole burst, so any number of words goes out under one selection. The bit rate comes from a parameter that sets how many system clocks each half of the serial clock period lasts. A fast-mode input, sampled when a request is accepted, shortens both halves to one system clock. Fast mode is intended for system clocks at or below 60 MHz.

Top module: `disp_ser_wr`

## Requirements
- R1: After reset, and whenever no transaction is running, `lcd_sck` is 1, `lcd_cs_n` is 1, `busy` is 0 and `done` is 0. Out of reset, `lcd_sda` is 1.
- R2: `lcd_sda` changes only in a cycle where `lcd_sck` is 0. It is stable while `lcd_sck` stays high. When idle it keeps its last value.
- R3: Frame bits are sent most significant bit first, one bit per rising edge of `lcd_sck`.
- R4: `lcd_rs` is 0 for a command or an extended command and 1 for a data burst. It holds steady while `lcd_cs_n` is low.
- R5: `lcd_cs_n` falls in the cycle after acceptance, while `lcd_sck` is still high. It rises one half period after the final rising `lcd_sck` edge.
- R6: `req_kind` 2'b00 sends `req_cmd` as an 8-bit frame. `req_kind` 2'b01 sends the 16-bit frame {`req_cmd`, `req_param`}.
- R7: `req_kind` 2'b1x sends `req_count` words from the word stream, back to back, under a single low period of `lcd_cs_n`. Each word is taken with `word_valid` and `word_ready` both high.
- R8: Each low phase of `lcd_sck` lasts `HALF_DIV` system clocks in normal mode and 1 clock when `fast_mode` was 1 at acceptance. Each high phase within a frame lasts the same.
- R9: A burst request with `req_count` of 0 is accepted. `done` pulses in the next cycle, `lcd_cs_n` stays 1 and `busy` stays 0.
- R10: `busy` is 1 from the cycle after acceptance until the cycle `lcd_cs_n` returns high. `req_ready` is 0 whenever `busy` is 1.
- R11: `done` is a one-cycle pulse in the first cycle with `lcd_cs_n` back high after a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 00 command, 01 extended command, 1x data burst |
| req_cmd | input | 8 | Command byte |
| req_param | input | 8 | Parameter byte for an extended command |
| req_count | input | CNT_W | Number of burst words |
| fast_mode | input | 1 | Use one-clock half periods for this request |
| word_valid | input | 1 | Burst word offered |
| word_ready | output | 1 | Burst word taken this cycle |
| word_data | input | 16 | Burst word |
| busy | output | 1 | Transaction running |
| done | output | 1 | Transaction finished pulse |
| lcd_cs_n | output | 1 | Active-low chip select |
| lcd_rs | output | 1 | Register select, 1 for data |
| lcd_sck | output | 1 | Serial clock, idles high |
| lcd_sda | output | 1 | Serial data |

## Verification
Counting from the clock edge that accepts a request, the timing is as follows. Chip select and busy change one cycle after that edge. The first falling serial clock edge comes two cycles after it when the frame source is ready. Each clock phase then takes H cycles, where H is `HALF_DIV`, or 1 in fast mode. Chip select and `done` follow the last rising edge by exactly H cycles, and a zero-count burst shows `done` one cycle after acceptance. The bench drives and samples one time unit after the falling system clock edge. A monitor counts how many such samples each serial clock phase spans and how many samples pass from the last rise to the release. The bench compares these counts with H, and reads the acceptance responses at the first sample after the accepting edge.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned BIT_W  = $clog2(WORD_W + 1);

  localparam logic [1:0] KIND_CMD = 2'b00;
  localparam logic [1:0] KIND_EXT = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH
  } ser_state_e;

  // A kind with the upper bit set is a data burst.
  function automatic logic kind_is_burst(logic [1:0] kind);
    return kind[1];
  endfunction

  // Command-type frames are left aligned so the shifter always uses the top bit.
  function automatic logic [WORD_W-1:0] cmd_frame(logic [1:0] kind,
                                                   logic [BYTE_W-1:0] cmd,
                                                   logic [BYTE_W-1:0] param);
    if (kind == KIND_EXT) return {cmd, param};
    return {cmd, {BYTE_W{1'b0}}};
  endfunction

  function automatic logic [BIT_W-1:0] frame_bits(logic [1:0] kind);
    if (kind == KIND_CMD) return BIT_W'(BYTE_W);
    return BIT_W'(WORD_W);
  endfunction

  function automatic int unsigned half_cycles(logic fast, int unsigned div);
    return fast ? 1 : div;
  endfunction
endpackage

// File: rtl/disp_ser_phase_timer.sv
module disp_ser_phase_timer #(
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [LEN_W-1:0] half_len,
  output logic             expire
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= half_len - 1'b1;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/disp_ser_shifter.sv
module disp_ser_shifter
  import disp_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] frame,
  input  logic [BIT_W-1:0]  nbits,
  input  logic              step,
  output logic              next_bit,
  output logic              last_bit
);
  logic [WORD_W-1:0] sr;
  logic [BIT_W-1:0]  left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= frame;
      left <= nbits;
    end else if (step) begin
      sr   <= {sr[WORD_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  // The top bit is on the line now; the one below it goes out next.
  assign next_bit = sr[WORD_W-2];
  assign last_bit = (left == BIT_W'(1));
endmodule

// File: rtl/disp_ser_wr.sv
module disp_ser_wr
  import disp_ser_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [BYTE_W-1:0] req_cmd,
  input  logic [BYTE_W-1:0] req_param,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              fast_mode,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              busy,
  output logic              done,
  output logic              lcd_cs_n,
  output logic              lcd_rs,
  output logic              lcd_sck,
  output logic              lcd_sda
);
  localparam int unsigned LEN_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV + 1);

  ser_state_e        state;
  logic [1:0]        kind_q;
  logic [BYTE_W-1:0] cmd_q, param_q;
  logic [CNT_W-1:0]  words_left;
  logic              burst_q, fast_q;
  logic              cs_n_q, rs_q, sck_q, sda_q, done_q;

  // Named internal events, also watched by the checker.
  logic              accept_evt, zero_evt, frame_go, bit_rise, bit_fall, frame_end;
  logic              expire, next_bit, last_bit;
  logic [WORD_W-1:0] frame_src;
  logic [LEN_W-1:0]  half_len;

  assign req_ready  = (state == ST_IDLE);
  assign accept_evt = req_valid && req_ready;
  assign zero_evt   = accept_evt && kind_is_burst(req_kind) && (req_count == '0);
  assign word_ready = (state == ST_LOAD) && burst_q;
  assign frame_go   = (state == ST_LOAD) && (!burst_q || word_valid);
  assign bit_rise   = (state == ST_LOW) && expire;
  assign bit_fall   = (state == ST_HIGH) && expire && !last_bit;
  assign frame_end  = (state == ST_HIGH) && expire && last_bit;
  assign frame_src  = burst_q ? word_data : cmd_frame(kind_q, cmd_q, param_q);
  assign half_len   = LEN_W'(half_cycles(fast_q, HALF_DIV));

  disp_ser_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (frame_go || bit_rise || bit_fall),
    .half_len (half_len),
    .expire   (expire)
  );

  disp_ser_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_go),
    .frame    (frame_src),
    .nbits    (burst_q ? BIT_W'(WORD_W) : frame_bits(kind_q)),
    .step     (bit_fall),
    .next_bit (next_bit),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind_q     <= KIND_CMD;
      cmd_q      <= '0;
      param_q    <= '0;
      words_left <= '0;
      burst_q    <= 1'b0;
      fast_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      rs_q       <= 1'b0;
      sck_q      <= 1'b1;
      sda_q      <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (zero_evt) begin
            done_q <= 1'b1;
          end else if (accept_evt) begin
            kind_q     <= req_kind;
            cmd_q      <= req_cmd;
            param_q    <= req_param;
            words_left <= req_count;
            burst_q    <= kind_is_burst(req_kind);
            fast_q     <= fast_mode;
            rs_q       <= kind_is_burst(req_kind);
            cs_n_q     <= 1'b0;
            state      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (frame_go) begin
            sck_q <= 1'b0;
            sda_q <= frame_src[WORD_W-1];
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (bit_rise) begin
            sck_q <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (bit_fall) begin
            sck_q <= 1'b0;
            sda_q <= next_bit;
            state <= ST_LOW;
          end else if (frame_end) begin
            if (burst_q && words_left > CNT_W'(1)) begin
              words_left <= words_left - 1'b1;
              state      <= ST_LOAD;
            end else begin
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign lcd_cs_n = cs_n_q;
  assign lcd_rs   = rs_q;
  assign lcd_sck  = sck_q;
  assign lcd_sda  = sda_q;
endmodule

// File: rtl/disp_ser_wr_chk.sv
module disp_ser_wr_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic lcd_cs_n,
  input logic lcd_rs,
  input logic lcd_sck,
  input logic lcd_sda,
  input logic accept_evt,
  input logic zero_evt
);
  // R1
  idle_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_cs_n |-> lcd_sck);

  // R2
  sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lcd_sda) |-> !lcd_sck);

  // R4
  rs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && !$past(lcd_cs_n)) |-> $stable(lcd_rs));

  // R5
  cs_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !zero_evt) |=> (!lcd_cs_n && lcd_sck));

  // R9
  zero_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (done && lcd_cs_n && !busy));

  // R10
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  // R10
  cs_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_cs_n |-> busy);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lcd_cs_n && !busy));
endmodule

bind disp_ser_wr disp_ser_wr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .busy       (busy),
  .done       (done),
  .lcd_cs_n   (lcd_cs_n),
  .lcd_rs     (lcd_rs),
  .lcd_sck    (lcd_sck),
  .lcd_sda    (lcd_sda),
  .accept_evt (accept_evt),
  .zero_evt   (zero_evt)
);

// File: tb/test_disp_ser_wr.sv
module test_disp_ser_wr;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [7:0]  req_cmd = 8'h00, req_param = 8'h00, req_count = 8'h00;
  logic        fast_mode = 1'b0;
  logic        word_valid = 1'b1;
  logic [15:0] word_data;
  logic        req_ready, word_ready, busy, done, lcd_cs_n, lcd_rs, lcd_sck, lcd_sda;

  always #4 clk = ~clk;

  disp_ser_wr #(.HALF_DIV(HALF), .CNT_W(8)) i_disp_ser_wr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_cmd(req_cmd), .req_param(req_param),
    .req_count(req_count), .fast_mode(fast_mode), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data), .busy(busy), .done(done),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_sck(lcd_sck), .lcd_sda(lcd_sda)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Word source for bursts.
  logic [15:0] words [4];
  int          widx = 0;
  logic        pend = 1'b0;
  assign word_data = words[widx[1:0]];

  // Line monitor, sampling on the falling system clock edge.
  logic [63:0] cap;
  int          n_rise, low_run, low_min, low_max, since, cs_rises;
  logic        prev_sck = 1'b1, prev_sda = 1'b1, prev_cs = 1'b1;
  logic        hold_bad, cs_bad, rs_seen;

  task automatic clear_mon();
    cap = '0; n_rise = 0; low_run = 0; low_min = 255; low_max = 0;
    since = 0; cs_rises = 0; hold_bad = 1'b0; cs_bad = 1'b0; rs_seen = 1'b0;
  endtask

  always @(negedge clk) begin
    if (pend) widx++;
    pend = word_ready && word_valid;
    if (rst_n) begin
      if (lcd_sck && !prev_sck) begin
        cap = {cap[62:0], lcd_sda};
        n_rise++;
        if (lcd_cs_n) cs_bad = 1'b1;
        rs_seen = lcd_rs;
        if (low_run < low_min) low_min = low_run;
        if (low_run > low_max) low_max = low_run;
        low_run = 0;
        since = 0;
      end else begin
        since++;
      end
      if (!lcd_sck) low_run++;
      if (lcd_sck && prev_sck && (lcd_sda != prev_sda)) hold_bad = 1'b1;
      if (lcd_cs_n && !prev_cs) cs_rises++;
    end
    prev_sck = lcd_sck;
    prev_sda = lcd_sda;
    prev_cs  = lcd_cs_n;
  end

  logic acc_cs, acc_busy, acc_ready, acc_sck, acc_done, fin_cs;
  int   fin_since;

  task automatic run_req(input logic [1:0] kind, input logic [7:0] cmd,
                         input logic [7:0] param, input logic [7:0] count,
                         input logic fast);
    @(negedge clk); #1;
    clear_mon();
    widx = 0;
    req_kind = kind; req_cmd = cmd; req_param = param;
    req_count = count; fast_mode = fast; req_valid = 1'b1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 1'b0;
    acc_cs = lcd_cs_n; acc_busy = busy; acc_ready = req_ready;
    acc_sck = lcd_sck; acc_done = done;
    if (!(kind[1] && count == 8'd0)) begin
      while (!done) begin @(negedge clk); #1; end
      fin_cs = lcd_cs_n;
      fin_since = since;
    end
  endtask

  // {kind, cmd, param, fast, expected frame, expected bits, expected rs}
  localparam logic [40:0] VEC [5] = '{
    {2'b00, 8'hA5, 8'h00, 1'b0, 16'h00A5, 5'd8,  1'b0},
    {2'b01, 8'h3C, 8'h81, 1'b0, 16'h3C81, 5'd16, 1'b0},
    {2'b00, 8'h00, 8'h77, 1'b1, 16'h0000, 5'd8,  1'b0},
    {2'b01, 8'hFF, 8'h00, 1'b1, 16'hFF00, 5'd16, 1'b0},
    {2'b00, 8'hFF, 8'h00, 1'b0, 16'h00FF, 5'd8,  1'b0}
  };

  task automatic common_checks(input int h);
    chk("R5", "cs_n after accept", acc_cs, 0);
    chk("R5", "sck high at select", acc_sck, 1);
    chk("R10", "busy after accept", acc_busy, 1);
    chk("R10", "ready while busy", acc_ready, 0);
    chk("R8", "low phase min", low_min, h);
    chk("R8", "low phase max", low_max, h);
    chk("R5", "cycles last rise to release", fin_since, h);
    chk("R11", "cs_n at done", fin_cs, 1);
    chk("R2", "sda moved in high phase", hold_bad, 0);
    chk("R7", "rise with cs_n high", cs_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    words[0] = 16'h8001; words[1] = 16'h7FFE; words[2] = 16'h0F0F; words[3] = 16'h0000;
    clear_mon();
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "sck", lcd_sck, 1);
    chk("R1", "cs_n", lcd_cs_n, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "sda", lcd_sda, 1);
    chk("R1", "ready", req_ready, 1);
    rst_n = 1'b1;

    // R3 R6 R4 command and extended frames from the table
    for (int i = 0; i < 5; i++) begin
      run_req(VEC[i][40:39], VEC[i][38:31], VEC[i][30:23], 8'd1, VEC[i][22]);
      chk("R3", "frame bits", cap[15:0], VEC[i][21:6]);
      chk("R6", "bit count", n_rise, VEC[i][5:1]);
      chk("R4", "rs for command", rs_seen, VEC[i][0]);
      common_checks(VEC[i][22] ? 1 : HALF);
    end

    // R7 three-word burst, normal rate
    run_req(2'b10, 8'h00, 8'h00, 8'd3, 1'b0);
    chk("R7", "burst bits", cap[47:0], {16'h8001, 16'h7FFE, 16'h0F0F});
    chk("R7", "burst bit count", n_rise, 48);
    chk("R7", "one cs release", cs_rises, 1);
    chk("R4", "rs for data", rs_seen, 1);
    common_checks(HALF);

    // R7 R8 two-word burst, fast rate, kind 2'b11
    words[0] = 16'hFFFF; words[1] = 16'h0000;
    run_req(2'b11, 8'h00, 8'h00, 8'd2, 1'b1);
    chk("R7", "fast burst bits", cap[31:0], {16'hFFFF, 16'h0000});
    chk("R7", "fast burst count", n_rise, 32);
    chk("R4", "rs for data fast", rs_seen, 1);
    common_checks(1);

    // R2 idle line keeps last value (last bit was 0)
    repeat (5) @(negedge clk);
    #1;
    chk("R2", "sda idle hold", lcd_sda, 0);
    chk("R1", "sck idle", lcd_sck, 1);

    // R9 zero-count burst
    run_req(2'b10, 8'h00, 8'h00, 8'd0, 1'b0);
    chk("R9", "done next cycle", acc_done, 1);
    chk("R9", "cs_n stays high", acc_cs, 1);
    chk("R9", "busy stays low", acc_busy, 0);
    repeat (10) @(negedge clk);
    #1;
    chk("R9", "no clock edges", n_rise, 0);
    chk("R9", "no cs activity", cs_rises, 0);
    chk("R10", "ready after zero burst", req_ready, 1);
    chk("R11", "done cleared", done, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule